// File: doc/BRIEF.md
# Receiver-clocked serial word transmitter

This block sends 32-bit words as a continuous serial bitstream to an external receiver. The receiver supplies the line clock. An internal source offers words through a ready/valid handshake. The block holds one word in a holding register and a second in a shift register, so the next word is always waiting when the current one ends. Words leave most significant bit first on the data line `td`. The active-low strobe `val_n` marks the start of the stream.

The receiver reports whether it can accept data on two inputs, `cts` and `rx_rdy`. Every register in the block changes on the falling edge of `line_clk`, so the receiver can sample `td` on the rising edge. Tying `cts` low and `rx_rdy` high gives a plain free-running serial output. The line clock may run at a variable rate; nothing inside the block depends on its frequency.

The sequencer has four states:
- **IDLE**: left by reset; `val_n` is high.
- **SEND**: a bit leaves on each falling edge where the receiver is ready.
- **PAUSE**: entered from SEND when the receiver withdraws readiness.
- **STARVE**: the shift register has run empty and the holding register has nothing to give it.

The transitions are:
- IDLE→SEND on the start edge.
- SEND→PAUSE when readiness drops.
- PAUSE→SEND when readiness returns.
- SEND or PAUSE→STARVE when the last bit leaves with no word held.
- STARVE→SEND when a word is held and the receiver is ready.

Top module: `sbo_port`

## Requirements
- R1: While `rst_n` is low, `val_n` is 1, `td` is 0 and `in_ready` is 1.
- R2: On each falling edge, the receiver counts as ready when `cts`=0, whatever `rx_rdy` is, and when `cts`=1 with `rx_rdy`=1. It counts as not ready when `cts`=1 with `rx_rdy`=0.
- R3: `val_n` goes from 1 to 0 on the first falling edge where the receiver is ready and a word is held. `td` does not change on that edge.
- R4: After the start edge, each falling edge where the receiver is ready drives the next bit onto `td`. A word's bits go out MSB (bit 31) first, down to bit 0.
- R5: When a word is held as the last bit of the current word is driven, bit 31 of the held word is driven on the next ready edge. No idle edge falls between the two words.
- R6: On an edge where the receiver is not ready, `td` keeps its value and no bit position advances. Shifting resumes with the next bit on the next ready edge.
- R7: When a word ends and no word is held, `td` keeps the last bit and `val_n` stays 0. On the first edge where a word is held and the receiver is ready, bit 31 of that word is driven.
- R8: Once `val_n` is 0 it stays 0 until reset.
- R9: A word on `in_data` is taken on a falling edge where `in_valid` and `in_ready` are both 1. `in_ready` is 1 when the holding register is empty. It is also 1 when the held word is moved into the shift register on that same edge.
- R10: With `cts`=0 and `rx_rdy`=1 held, a stream of available words leaves as an unbroken bit sequence, one bit per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| line_clk | input | 1 | Line clock from the receiver; all registers change on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts | input | 1 | Receiver readiness input; 0 means ready |
| rx_rdy | input | 1 | Second receiver readiness input; examined only when `cts` is 1 |
| in_valid | input | 1 | Upstream word offered |
| in_ready | output | 1 | Holding register can take a word on this edge |
| in_data | input | 32 | Upstream word |
| val_n | output | 1 | Active-low stream-valid strobe |
| td | output | 1 | Serial data line |

## Verification
On one edge, the block can both move the held word into the shift register as the last bit leaves and take a fresh upstream word into the holding register. The bench provokes this by keeping `in_valid` high during long back-to-back runs. The reference model predicts `in_ready` from its own holding-register occupancy and its own hand-off decision, and `in_ready` is compared after the inputs settle on every cycle. Readiness is also dropped and restored across word boundaries, so a pause that lands on a last bit is judged cycle by cycle against the model's bit queue.

// File: rtl/sbo_pkg.sv
package sbo_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEND   = 2'd1,
        ST_PAUSE  = 2'd2,
        ST_STARVE = 2'd3
    } sbo_state_t;
endpackage

// File: rtl/sbo_ready_decode.sv
module sbo_ready_decode (
    input  logic cts,
    input  logic rx_rdy,
    output logic line_ok
);
    // not ready only for cts=1, rx_rdy=0
    assign line_ok = ~cts | rx_rdy;
endmodule

// File: rtl/sbo_prefetch.sv
module sbo_prefetch #(
    parameter int W = 32
) (
    input  logic         line_clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    input  logic         take,
    output logic         in_ready,
    output logic         full,
    output logic [W-1:0] hold_data
);
    assign in_ready = ~full | take;

    always_ff @(negedge line_clk or negedge rst_n) begin
        if (!rst_n) begin
            full      <= 1'b0;
            hold_data <= '0;
        end else if (in_valid && in_ready) begin
            full      <= 1'b1;
            hold_data <= in_data;
        end else if (take) begin
            full      <= 1'b0;
        end
    end
endmodule

// File: rtl/sbo_shifter.sv
module sbo_shifter
    import sbo_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         line_clk,
    input  logic         rst_n,
    input  logic         line_ok,
    input  logic         full,
    input  logic [W-1:0] hold_data,
    output logic         take,
    output logic         val_n,
    output logic         td
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    sbo_state_t     state, state_nx;
    logic [W-1:0]   sreg;
    logic [CW-1:0]  cnt;
    logic           last_bit;

    assign last_bit = (cnt == LAST);

    always_comb begin
        state_nx = state;
        take     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (line_ok && full) begin
                    state_nx = ST_SEND;
                    take     = 1'b1;
                end
            end
            ST_SEND, ST_PAUSE: begin
                if (!line_ok) begin
                    state_nx = ST_PAUSE;
                end else if (last_bit && !full) begin
                    state_nx = ST_STARVE;
                end else begin
                    state_nx = ST_SEND;
                    take     = last_bit;
                end
            end
            ST_STARVE: begin
                if (line_ok && full) begin
                    state_nx = ST_SEND;
                    take     = 1'b1;
                end
            end
        endcase
    end

    always_ff @(negedge line_clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(negedge line_clk or negedge rst_n) begin
        if (!rst_n) begin
            val_n <= 1'b1;
            td    <= 1'b0;
            sreg  <= '0;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (take) begin
                        val_n <= 1'b0;
                        sreg  <= hold_data;
                        cnt   <= '0;
                    end
                end
                ST_SEND, ST_PAUSE: begin
                    if (line_ok) begin
                        td <= sreg[W-1];
                        if (last_bit) begin
                            cnt <= '0;
                            if (take) sreg <= hold_data;
                        end else begin
                            sreg <= sreg << 1;
                            cnt  <= cnt + 1'b1;
                        end
                    end
                end
                ST_STARVE: begin
                    if (take) begin
                        td   <= hold_data[W-1];
                        sreg <= hold_data << 1;
                        cnt  <= CW'(1);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/sbo_port.sv
module sbo_port #(
    parameter int W = 32
) (
    input  logic         line_clk,
    input  logic         rst_n,
    input  logic         cts,
    input  logic         rx_rdy,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         val_n,
    output logic         td
);
    logic         line_ok;
    logic         take;
    logic         full;
    logic [W-1:0] hold_data;

    sbo_ready_decode u_dec (
        .cts     (cts),
        .rx_rdy  (rx_rdy),
        .line_ok (line_ok)
    );

    sbo_prefetch #(.W(W)) u_pf (
        .line_clk  (line_clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .take      (take),
        .in_ready  (in_ready),
        .full      (full),
        .hold_data (hold_data)
    );

    sbo_shifter #(.W(W)) u_sh (
        .line_clk  (line_clk),
        .rst_n     (rst_n),
        .line_ok   (line_ok),
        .full      (full),
        .hold_data (hold_data),
        .take      (take),
        .val_n     (val_n),
        .td        (td)
    );
endmodule

// File: rtl/sbo_port_chk.sv
module sbo_port_chk (
    input logic line_clk,
    input logic rst_n,
    input logic cts,
    input logic rx_rdy,
    input logic val_n,
    input logic td
);
    logic rx_ok;
    assign rx_ok = !(cts && !rx_rdy);

    // R8: strobe sticks low once asserted
    a_r8_val_sticky: assert property (@(negedge line_clk) disable iff (!rst_n)
        !val_n |=> !val_n);

    // R6: an edge without readiness leaves the data line alone
    a_r6_pause_holds_td: assert property (@(negedge line_clk) disable iff (!rst_n)
        !rx_ok |=> $stable(td));

    // R2: an edge without readiness cannot start the stream
    a_r2_not_ready_no_start: assert property (@(negedge line_clk) disable iff (!rst_n)
        !rx_ok |=> $stable(val_n));

    // R3: the start edge carries no data bit
    a_r3_start_no_bit: assert property (@(negedge line_clk) disable iff (!rst_n)
        $fell(val_n) |-> $stable(td));
endmodule

bind sbo_port sbo_port_chk u_chk (
    .line_clk (line_clk),
    .rst_n    (rst_n),
    .cts      (cts),
    .rx_rdy   (rx_rdy),
    .val_n    (val_n),
    .td       (td)
);

// File: tb/sbo_port_tb.sv
`timescale 1ns/1ps
module sbo_port_tb;
    localparam int W = 32;

    logic         line_clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cts = 1'b1;
    logic         rx_rdy = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] in_data = '0;
    logic         val_n;
    logic         td;

    always #4 line_clk = ~line_clk;

    sbo_port #(.W(W)) u_dut (
        .line_clk (line_clk),
        .rst_n    (rst_n),
        .cts      (cts),
        .rx_rdy   (rx_rdy),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .val_n    (val_n),
        .td       (td)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;
    string cur_req = "R1";

    // reference model
    bit         m_started = 0;
    bit         m_val_n = 1;
    bit         m_td = 0;
    bit         m_bits[$];
    logic [W-1:0] m_hold[$];

    // source
    logic [W-1:0] words[0:255];
    int src_idx = 0;
    bit supply = 0;
    bit d_cts = 1, d_rdy = 0;

    function automatic bit m_ok(bit c, bit r);
        return (c == 0) || (r == 1);
    endfunction

    function automatic bit m_take(bit ok);
        if (!ok || m_hold.size() == 0) return 0;
        return (!m_started) || (m_bits.size() <= 1);
    endfunction

    function automatic bit m_inrdy(bit ok);
        return (m_hold.size() == 0) || m_take(ok);
    endfunction

    task automatic m_load();
        logic [W-1:0] w;
        w = m_hold.pop_front();
        m_bits.delete();
        for (int i = W - 1; i >= 0; i--) m_bits.push_back(w[i]);
    endtask

    task automatic check(string what, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual %b expected %b at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic cycle();
        bit ok, tk, acc;
        @(posedge line_clk);
        check("val_n", val_n, m_val_n);
        check("td", td, m_td);
        cts      = d_cts;
        rx_rdy   = d_rdy;
        in_valid = supply;
        in_data  = words[src_idx % 256];
        #1;
        ok = m_ok(d_cts, d_rdy);
        check("in_ready", in_ready, m_inrdy(ok));
        @(negedge line_clk);
        tk  = m_take(ok);
        acc = supply && ((m_hold.size() == 0) || tk);
        if (!m_started) begin
            if (tk) begin
                m_started = 1;
                m_val_n = 0;
                m_load();
            end
        end else if (ok) begin
            if (m_bits.size() == 0) begin
                if (tk) begin
                    m_load();
                    m_td = m_bits.pop_front();
                end
            end else begin
                m_td = m_bits.pop_front();
                if (m_bits.size() == 0 && tk) m_load();
            end
        end
        if (acc) begin
            m_hold.push_back(words[src_idx % 256]);
            src_idx++;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [W-1:0] s;
        s = 32'h1234_5678;
        words[0] = 32'h8000_0001;
        words[1] = 32'hFFFF_0000;
        for (int i = 2; i < 256; i++) begin
            s = s * 32'd1664525 + 32'd1013904223;
            words[i] = s;
        end

        // R1: reset values
        #21;
        check("val_n", val_n, 1'b1);
        check("td", td, 1'b0);
        check("in_ready", in_ready, 1'b1);
        @(posedge line_clk);
        #1 rst_n = 1'b1;

        // R2, R3: word available but cts=1 rx_rdy=0 holds start off
        cur_req = "R2";
        d_cts = 1; d_rdy = 0; supply = 1;
        repeat (6) cycle();
        supply = 0;
        repeat (4) cycle();
        cur_req = "R3";
        d_cts = 1; d_rdy = 1;
        repeat (3) cycle();

        // R4: MSB first, one bit per ready edge
        cur_req = "R4";
        supply = 1;
        repeat (40) cycle();

        // R2, R6: all four readiness combinations mid-stream
        cur_req = "R6";
        for (int k = 0; k < 300; k++) begin
            case ((k / 3 + k / 7) % 4)
                0: begin d_cts = 1; d_rdy = 0; end
                1: begin d_cts = 0; d_rdy = 0; end
                2: begin d_cts = 0; d_rdy = 1; end
                default: begin d_cts = 1; d_rdy = 1; end
            endcase
            cycle();
        end

        // R5, R9: back-to-back words with refill on hand-off edges
        cur_req = "R5";
        d_cts = 1; d_rdy = 1;
        repeat (200) cycle();

        // R7, R8: underrun, then resume
        cur_req = "R7";
        supply = 0;
        repeat (90) cycle();
        cur_req = "R8";
        d_cts = 1; d_rdy = 0;
        repeat (5) cycle();
        cur_req = "R7";
        supply = 1;
        repeat (3) cycle();
        d_cts = 0; d_rdy = 0;
        repeat (50) cycle();

        // R9: source toggling
        cur_req = "R9";
        for (int k = 0; k < 200; k++) begin
            supply = (k % 45) < 30;
            cycle();
        end

        // R10: plain free-running output
        cur_req = "R10";
        d_cts = 0; d_rdy = 1; supply = 1;
        repeat (400) cycle();

        finish_run();
    end
endmodule